// File: doc/BRIEF.md
# I2C START/STOP condition sequencer

This block sits beside the byte engine of an I2C master. It watches the synchronized SDA and SCL lines at all times and keeps a bus-busy flag, set by any START on the wire and cleared by any STOP. This includes traffic between other devices. On request it produces the framing conditions itself: a START when the bus has been free long enough, a repeated START in the middle of a session, and a STOP at the end of one. It reports each one with a single-cycle done pulse and a kind code.

The requests are level flags of the kind a control register holds. A START request that cannot be served is neither lost nor acted upon; it stays pending until the bus becomes free. The STOP request is cleared by hardware: a clear pulse is raised when the STOP is seen back on the wire. When both requests are set in a session, the block closes the session first. It then treats the START as a fresh one and waits out the bus-free interval. After any START the block holds SCL and SDA low, which keeps the bus owned, until its next condition. Lines are open-drain: an output of 1 means "pull the line low".

Top module: `i2c_cond_seq`

## Requirements
- R1: bus_busy goes to 1 a few cycles after SDA falls while SCL is high, and returns to 0 after SDA rises while SCL is high. This holds whether the lines are moved by this block or by another device.
- R2: With start_req set, the block not owning the bus and the bus free, the block issues a START. Both lines are high for at least T_SU cycles, then SDA is pulled low while SCL is high. SCL follows low at least T_HD cycles later, together with one cond_done pulse with cond_kind = 1. After that, scl_low_en and sda_low_en stay 1.
- R3: A START request made while the bus is busy drives nothing and stays pending. The bus counts as free only T_BUF or more cycles after a STOP on the wire, or after reset. The START that finally follows comes at least T_BUF cycles after the last STOP.
- R4: While the block owns the bus, start_req with master_act = 1 and byte_cnt not zero gives a repeated START. No STOP appears on the wire in between, and cond_kind = 2.
- R5: While the block owns the bus, a START request with byte_cnt = 0 has no effect. Once byte_cnt becomes nonzero, it is served as a repeated START.
- R6: While the block owns the bus, stop_req with master_act = 1 drives a STOP: SDA rises while SCL is high. When that STOP is detected, cond_done (cond_kind = 3) and stop_clr pulse in the same cycle, and bus_busy is 0.
- R7: start_req and stop_req set together while owning the bus give a STOP first. A START follows, at least T_BUF cycles after that STOP.
- R8: With both requests at 0, no condition is generated and the line drives keep their values.
- R9: stop_req is ignored while master_act is 0 or while the block does not own the bus.
- R10: After reset both drives, cond_done, stop_clr and bus_busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| start_req | input | 1 | START request flag |
| stop_req | input | 1 | STOP request flag |
| master_act | input | 1 | Byte engine reports an active master session |
| byte_cnt | input | CNT_W | Bytes moved in the current session |
| scl_low_en | output | 1 | Pull SCL low |
| sda_low_en | output | 1 | Pull SDA low |
| cond_done | output | 1 | One-cycle pulse when a condition is complete |
| cond_kind | output | 2 | 1 START, 2 repeated START, 3 STOP, 0 while no pulse |
| stop_clr | output | 1 | Hardware clear of the STOP request |
| bus_busy | output | 1 | Bus busy flag |

## Verification
Several patterns are driven. Requests on a free bus show that set-up and hold timing is met. Requests made during foreign traffic show that a START is deferred rather than lost or forced. Requests inside an owned session, with zero and nonzero byte counts, separate a repeated START from an ignored request. The combined STOP-and-START request checks the order of the two conditions and the bus-free gap between them. Requests with master_act low, and requests with neither flag set, show that nothing moves, and a random walk over all of these against a bench model of the expected condition covers the orderings between them.

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int T_BUF = 20,
  parameter int T_SU  = 6,
  parameter int T_HD  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             master_act,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             scl_low_en,
  output logic             sda_low_en,
  output logic             cond_done,
  output logic [1:0]       cond_kind,
  output logic             stop_clr,
  output logic             bus_busy
);
  localparam int TMAX = (T_SU > T_HD) ? T_SU : T_HD;
  localparam int TW   = $clog2(TMAX + 2);
  localparam int BW   = $clog2(T_BUF + 2);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SSU, ST_SHD, ST_OWN, ST_RSDA, ST_RSCL, ST_PSDA, ST_PSCL, ST_PREL
  } st_t;

  st_t st, st_nx;
  logic [1:0] scl_ff, sda_ff;
  logic sda_q, busy_q, owned, rs_q;
  logic [BW-1:0] free_cnt;
  logic [TW-1:0] tmr;

  wire scl_s    = scl_ff[1];
  wire sda_s    = sda_ff[1];
  wire start_det = scl_s & sda_q & ~sda_s;
  wire stop_det  = scl_s & ~sda_q & sda_s;
  wire bus_free  = ~busy_q & (free_cnt >= BW'(T_BUF));
  wire su_ok     = tmr >= TW'(T_SU);
  wire hd_ok     = tmr >= TW'(T_HD);
  wire wait_scl  = (st == ST_RSCL) || (st == ST_PSCL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q   <= 1'b0;
      free_cnt <= '0;
    end else begin
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
      if (busy_q || start_det)            free_cnt <= '0;
      else if (free_cnt < BW'(T_BUF))     free_cnt <= free_cnt + 1'b1;
    end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start_req && bus_free) st_nx = ST_SSU;
      ST_SSU:  if (su_ok) st_nx = ST_SHD;
      ST_SHD:  if (hd_ok) st_nx = ST_OWN;
      ST_OWN:
        if (master_act && stop_req)                          st_nx = ST_PSDA;
        else if (master_act && start_req && byte_cnt != '0)  st_nx = ST_RSDA;
      ST_RSDA: if (su_ok) st_nx = ST_RSCL;
      ST_RSCL: if (scl_s && su_ok) st_nx = ST_SHD;
      ST_PSDA: if (su_ok) st_nx = ST_PSCL;
      ST_PSCL: if (scl_s && su_ok) st_nx = ST_PREL;
      ST_PREL: if (stop_det) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      owned     <= 1'b0;
      rs_q      <= 1'b0;
      cond_done <= 1'b0;
      cond_kind <= 2'd0;
      stop_clr  <= 1'b0;
    end else begin
      st        <= st_nx;
      cond_done <= 1'b0;
      cond_kind <= 2'd0;
      stop_clr  <= 1'b0;
      if (st_nx != st || (wait_scl && !scl_s)) tmr <= '0;
      else if (tmr != {TW{1'b1}})               tmr <= tmr + 1'b1;
      if (st == ST_OWN && st_nx == ST_RSDA) rs_q <= 1'b1;
      if (st == ST_SHD && hd_ok) begin
        owned     <= 1'b1;
        rs_q      <= 1'b0;
        cond_done <= 1'b1;
        cond_kind <= rs_q ? 2'd2 : 2'd1;
      end
      if (st == ST_PREL && stop_det) begin
        owned     <= 1'b0;
        cond_done <= 1'b1;
        cond_kind <= 2'd3;
        stop_clr  <= 1'b1;
      end
    end

  assign scl_low_en = (st == ST_OWN) || (st == ST_RSDA) || (st == ST_PSDA);
  assign sda_low_en = (st == ST_SHD) || (st == ST_OWN) || (st == ST_PSDA) || (st == ST_PSCL);
  assign bus_busy   = busy_q;

  // R6: the request clear comes only with the STOP completion
  a_r6_clear_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |-> (cond_done && cond_kind == 2'd3));
  a_r6_stop_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_done && cond_kind == 2'd3) |-> !bus_busy);
  // R4: a repeated START never follows a STOP seen on the bus
  a_r4_rstart_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_done && cond_kind == 2'd2) |-> bus_busy);
  // R2: after any START the clock is held low
  a_r2_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_done && (cond_kind == 2'd1 || cond_kind == 2'd2)) |-> scl_low_en);
  // R3: a fresh START only when the bus was seen idle
  a_r3_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low_en) && !owned) |-> !busy_q);
  // R5: no byte moved, no repeated START
  a_r5_zero_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OWN && byte_cnt == '0 && !stop_req) |=> st == ST_OWN);
  // R9: stop ignored without an active master
  a_r9_stop_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OWN && !master_act) |=> st == ST_OWN);
  // R8: no request, no condition from idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start_req) |=> (!sda_low_en && !scl_low_en));
endmodule

// File: tb/i2c_cond_seq_bench.sv
module i2c_cond_seq_bench;
  localparam int T_BUF = 20, T_SU = 6, T_HD = 6;
  logic clk = 0, rst_n = 0;
  logic start_req = 0, stop_req = 0, master_act = 1;
  logic [7:0] byte_cnt = 0;
  logic ext_scl_lo = 0, ext_sda_lo = 0;
  logic scl_low_en, sda_low_en, cond_done, stop_clr, bus_busy;
  logic [1:0] cond_kind;
  wire scl_w = !(scl_low_en || ext_scl_lo);
  wire sda_w = !(sda_low_en || ext_sda_lo);

  i2c_cond_seq #(.T_BUF(T_BUF), .T_SU(T_SU), .T_HD(T_HD), .CNT_W(8)) u_i2c_cond_seq (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_w), .sda_in(sda_w),
    .start_req(start_req), .stop_req(stop_req), .master_act(master_act),
    .byte_cnt(byte_cnt), .scl_low_en(scl_low_en), .sda_low_en(sda_low_en),
    .cond_done(cond_done), .cond_kind(cond_kind), .stop_clr(stop_clr), .bus_busy(bus_busy));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0, hi_run = 0, last_stop = 0, gap_last = 0, su_last = 0;
  int hold_cnt = 0, hd_last = 0, n_bus_start = 0, n_bus_stop = 0, n_done = 0;
  bit in_hold = 0, prev_scl = 1, prev_sda = 1;

  always @(negedge clk) begin
    #1;
    cyc++;
    if (!rst_n) begin
      last_stop = cyc; prev_scl = 1; prev_sda = 1; hi_run = 0;
    end else begin
      if (prev_scl && scl_w && prev_sda && !sda_w) begin
        n_bus_start++; gap_last = cyc - last_stop; su_last = hi_run;
        in_hold = 1; hold_cnt = 0;
      end
      if (prev_scl && scl_w && !prev_sda && sda_w) begin
        n_bus_stop++; last_stop = cyc;
      end
      if (in_hold) begin
        if (scl_w) hold_cnt++;
        else begin in_hold = 0; hd_last = hold_cnt; end
      end
      hi_run = (scl_w && sda_w) ? hi_run + 1 : 0;
      if (cond_done) n_done++;
      prev_scl = scl_w; prev_sda = sda_w;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_done(input int lim, output int k, output int clr);
    k = 0; clr = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); #2;
      if (cond_done) begin k = cond_kind; clr = stop_clr; break; end
    end
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int d0 = n_done;
    cycles(n);
    chk(n_done == d0, tag, n_done - d0, 0);
  endtask

  task automatic ext_start();
    ext_sda_lo = 1; cycles(10); ext_scl_lo = 1; cycles(10);
  endtask

  task automatic ext_stop();
    ext_sda_lo = 1; cycles(10); ext_scl_lo = 0; cycles(10); ext_sda_lo = 0; cycles(10);
  endtask

  function automatic int exp_kind(input bit own, input bit sta, input bit sto,
                                  input bit mst, input int bytes);
    if (!own) return sta ? 1 : 0;
    if (!mst) return 0;
    if (sto) return 3;
    if (sta && bytes != 0) return 2;
    return 0;
  endfunction

  task automatic fresh_start(input string tag);
    int k, c;
    start_req = 1;
    wait_done(400, k, c);
    start_req = 0;
    chk(k == 1, {tag, " START kind"}, k, 1);
    chk(gap_last >= T_BUF, "R3 bus-free gap before START", gap_last, T_BUF);
    cycles(2);
    chk(su_last >= T_SU && hd_last >= T_HD, "R2 set-up/hold", su_last * 100 + hd_last, T_SU * 100 + T_HD);
    chk(scl_low_en && sda_low_en && bus_busy, "R2 bus held after START",
        {scl_low_en, sda_low_en, bus_busy}, 7);
  endtask

  task automatic do_stop(input string tag);
    int k, c, s0 = n_bus_stop;
    stop_req = 1;
    wait_done(400, k, c);
    stop_req = 0;
    chk(k == 3 && c == 1, {tag, " STOP kind/clear"}, k * 10 + c, 31);
    chk(!bus_busy && n_bus_stop == s0 + 1, "R6 STOP on bus, busy cleared",
        n_bus_stop - s0, 1);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, c, s0, r, bytes;
    bit own;
    void'($urandom(32'h5eed1234));
    cycles(5);
    chk(!scl_low_en && !sda_low_en && !cond_done && !stop_clr && !bus_busy,
        "R10 reset state", {scl_low_en, sda_low_en, cond_done, stop_clr, bus_busy}, 0);
    rst_n = 1;

    fresh_start("R2");
    expect_quiet(40, "R8 no request no condition");
    chk(scl_low_en && sda_low_en, "R8 drives held", {scl_low_en, sda_low_en}, 3);

    master_act = 0; stop_req = 1;
    expect_quiet(40, "R9 STOP without master_act");
    chk(scl_low_en && sda_low_en, "R9 drives held", {scl_low_en, sda_low_en}, 3);
    master_act = 1;
    do_stop("R6");

    stop_req = 1;
    expect_quiet(40, "R9 STOP when not owner");
    chk(!scl_low_en && !sda_low_en, "R9 no drive", {scl_low_en, sda_low_en}, 0);
    stop_req = 0;

    ext_start(); cycles(5);
    chk(bus_busy, "R1 busy on foreign START", bus_busy, 1);
    ext_stop(); cycles(5);
    chk(!bus_busy, "R1 free on foreign STOP", bus_busy, 0);

    ext_start(); start_req = 1;
    expect_quiet(60, "R3 START pending while busy");
    chk(!sda_low_en && !scl_low_en, "R3 no drive while busy", {scl_low_en, sda_low_en}, 0);
    ext_stop();
    fresh_start("R3");

    byte_cnt = 0; start_req = 1;
    expect_quiet(50, "R5 zero bytes no repeated START");
    s0 = n_bus_stop;
    byte_cnt = 3;
    wait_done(400, k, c);
    start_req = 0;
    chk(k == 2, "R5 pending served as repeated START", k, 2);
    chk(n_bus_stop == s0 && bus_busy, "R4 no STOP before repeated START", n_bus_stop - s0, 0);

    start_req = 1; stop_req = 1;
    wait_done(400, k, c);
    stop_req = 0;
    chk(k == 3 && c == 1, "R7 STOP first", k, 3);
    wait_done(400, k, c);
    start_req = 0;
    chk(k == 1, "R7 START second", k, 1);
    chk(gap_last >= T_BUF, "R7 bus-free gap", gap_last, T_BUF);
    own = 1;

    for (int it = 0; it < 40; it++) begin
      int e;
      bit sta, sto;
      if (!own) begin
        if ($urandom_range(0, 1) == 1) begin
          ext_start(); start_req = 1; cycles($urandom_range(5, 40)); ext_stop();
        end
        fresh_start("R2 random");
        own = 1;
        continue;
      end
      r = $urandom_range(0, 3);
      sta = (r != 1); sto = (r == 1 || r == 2);
      bytes = (r == 3) ? 0 : $urandom_range(1, 200);
      byte_cnt = bytes[7:0];
      s0 = n_bus_stop;
      e = exp_kind(own, sta, sto, 1'b1, bytes);
      start_req = sta; stop_req = sto;
      if (e == 0) begin
        expect_quiet(30, "R5 random zero bytes");
        byte_cnt = 8'd1;
        e = 2;
      end
      wait_done(400, k, c);
      stop_req = 0;
      chk(k == e, "R4/R6 random condition kind", k, e);
      if (e == 2) chk(n_bus_stop == s0, "R4 random no STOP", n_bus_stop - s0, 0);
      if (e == 3) begin
        chk(c == 1, "R6 random stop clear", c, 1);
        own = 0;
        if (sta) begin
          wait_done(400, k, c);
          chk(k == 1 && gap_last >= T_BUF, "R7 random START after STOP", k, 1);
          own = 1;
        end
      end
      start_req = 0;
      cycles($urandom_range(1, 10));
    end
    if (own) do_stop("R6 final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule